// File: doc/BRIEF.md
# Complex Q1.15 Matrix Multiplier

This block computes C = A·B for complex matrices: A is M×P, B is P×N and C is M×N. Every element is a complex fixed-point number held as two consecutive signed 16-bit words (real word at the even address, imaginary word at the odd one), with matrices laid out row-major. The block reads A and B through word-addressed read ports with same-cycle data. It writes C through a word-addressed write port.

A one-cycle `start` pulse captures the six dimension inputs. The block then checks that they agree. If they do not, it ends at once with an error status. If they do, it first copies B into an internal scratch store in column order, so that each column of B becomes one contiguous run of complex pairs. It then walks the output row by row. For every output element it forms a full-precision complex dot product in two wide accumulators. Each sum is shifted right by 15 places with no rounding, clamped to the signed 16-bit range, and written out as a real/imaginary word pair.

Top module: `cplx_matmul`

## Requirements
- R1: If the A column count differs from the B row count, or the C row count differs from the A row count, or the C column count differs from the B column count, the block sets `status` to 1, pulses `done`, and makes no write to C.
- R2: When the three dimension conditions hold, `status` is 0 when `done` pulses.
- R3: The real word of output (i,j) equals sat16((Σk ar·br − ai·bi) >>> 15), where the sum is taken exactly in at least 64 bits.
- R4: The imaginary word of output (i,j) equals sat16((Σk ar·bi + ai·br) >>> 15), taken the same way.
- R5: The right shift truncates toward minus infinity with no rounding: a sum of −3 yields −1, not 0.
- R6: A sum whose shifted value exceeds 32767 yields 32767, including P terms of (−32768)·(−32768).
- R7: A sum whose shifted value is below −32768 yields −32768.
- R8: C is written only at word address 2·(i·N+j) for the real part and that address plus 1 for the imaginary part. The writes come in ascending address order starting at 0, one word per write cycle, for exactly 2·M·N writes.
- R9: `done` is high for exactly one cycle, after the last C write. The dimensions are sampled only in the `start` cycle, so changing them later has no effect on the running operation.
- R10: Every dimension from 1 to 16 is handled, including P odd and P = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; samples the dimensions |
| dim_am | input | 5 | Rows of A |
| dim_ap | input | 5 | Columns of A |
| dim_bp | input | 5 | Rows of B |
| dim_bn | input | 5 | Columns of B |
| dim_cm | input | 5 | Rows of C |
| dim_cn | input | 5 | Columns of C |
| done | output | 1 | One-cycle completion pulse |
| status | output | 1 | 0 = success, 1 = dimension mismatch |
| a_addr | output | 9 | A word address |
| a_rdata | input | 16 | A word read data (same cycle) |
| b_addr | output | 9 | B word address |
| b_rdata | input | 16 | B word read data (same cycle) |
| c_we | output | 1 | C write enable |
| c_addr | output | 9 | C word address |
| c_wdata | output | 16 | C write data |

## Verification
The bench drives the extreme corners of the number format. All-(−32768) operands must clamp to 32767; a design that truncated the accumulator or wrapped instead of clamping would produce a negative or small value. A strongly negative sum must clamp to −32768. A run of −1 products must give −1; a design that rounded or shifted logically would give 0 or a large positive word. Shapes with P = 1, odd P, a single element and the full 16×16×16 size catch off-by-one errors in the transpose and inner-loop counters; such errors show up as shifted or missing elements. Each of the three mismatch conditions must stop the block with no C write. The dimension inputs are changed right after `start`, which exposes a design that reads them live.

// File: rtl/cmm_pkg.sv
package cmm_pkg;

    localparam int MAXD = 16;                  // largest dimension
    localparam int DW   = $clog2(MAXD + 1);    // width of a dimension value
    localparam int IW   = $clog2(MAXD);        // width of an index
    localparam int AW   = 2 * IW + 1;          // word address width
    localparam int SDEPTH = 2 * MAXD * MAXD;   // scratch words
    localparam int ACCW = 64;                  // accumulator width

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CHECK,
        SQ_XPOSE,
        SQ_MAC,
        SQ_WR_RE,
        SQ_WR_IM,
        SQ_FIN
    } seq_state_t;

    typedef struct packed {
        logic signed [15:0] re;
        logic signed [15:0] im;
    } cq15_t;

    typedef struct packed {
        logic [DW-1:0] am;
        logic [DW-1:0] ap;
        logic [DW-1:0] bp;
        logic [DW-1:0] bn;
        logic [DW-1:0] cm;
        logic [DW-1:0] cn;
    } dims_t;

    // Drop 15 fraction bits (toward minus infinity), then clamp to 16 bits.
    function automatic logic signed [15:0] sat_q15(input logic signed [ACCW-1:0] acc);
        logic signed [ACCW-1:0] sh;
        sh = acc >>> 15;
        if (sh > 64'sd32767)
            return 16'sh7FFF;
        else if (sh < -64'sd32768)
            return 16'sh8000;
        else
            return sh[15:0];
    endfunction

endpackage

// File: rtl/cmm_scratch.sv
module cmm_scratch
    import cmm_pkg::*;
(
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [15:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [15:0]   rdata
);

    logic [15:0] mem [SDEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/cmm_mac.sv
module cmm_mac
    import cmm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        lo_en,     // real words present: hold them
    input  logic        hi_en,     // imaginary words present: accumulate
    input  logic        first,     // first term of a dot product
    input  logic [15:0] a_word,
    input  logic [15:0] b_word,
    output cq15_t       res
);

    logic signed [15:0] a_hold, b_hold;
    logic signed [ACCW-1:0] acc_re, acc_im;
    logic signed [31:0] xa_re, xb_re, xa_im, xb_im;
    logic signed [31:0] p_rr, p_ii, p_ri, p_ir;
    logic signed [ACCW-1:0] t_re, t_im;

    always_comb begin
        xa_re = 32'(a_hold);
        xb_re = 32'(b_hold);
        xa_im = 32'($signed(a_word));
        xb_im = 32'($signed(b_word));
        p_rr  = xa_re * xb_re;
        p_ii  = xa_im * xb_im;
        p_ri  = xa_re * xb_im;
        p_ir  = xa_im * xb_re;
        t_re  = ACCW'(p_rr) - ACCW'(p_ii);
        t_im  = ACCW'(p_ri) + ACCW'(p_ir);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_hold <= '0;
            b_hold <= '0;
            acc_re <= '0;
            acc_im <= '0;
        end else begin
            if (lo_en) begin
                a_hold <= $signed(a_word);
                b_hold <= $signed(b_word);
            end
            if (hi_en) begin
                acc_re <= (first ? '0 : acc_re) + t_re;
                acc_im <= (first ? '0 : acc_im) + t_im;
            end
        end
    end

    assign res.re = sat_q15(acc_re);
    assign res.im = sat_q15(acc_im);

    // R3: the real half and the imaginary half of a term never arrive together
    a_r3_phase_split: assert property (@(posedge clk) disable iff (rst)
        !(lo_en && hi_en));

    // R3: an accumulate step always follows a hold step
    a_r3_hold_then_acc: assert property (@(posedge clk) disable iff (rst)
        lo_en |=> hi_en);

endmodule

// File: rtl/cmm_seq.sv
module cmm_seq
    import cmm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  dims_t         dims_in,
    output logic          done,
    output logic          status,
    output logic [AW-1:0] a_addr,
    output logic [AW-1:0] b_addr,
    output logic          sc_we,
    output logic [AW-1:0] sc_waddr,
    output logic [AW-1:0] sc_raddr,
    output logic          mac_lo,
    output logic          mac_hi,
    output logic          mac_first,
    output logic          c_we,
    output logic [AW-1:0] c_addr,
    output logic          sel_im
);

    seq_state_t    st;
    dims_t         dq;
    logic [DW-1:0] r, c, k;
    logic          part;
    logic [AW-1:0] b_ptr, a_base, c_ptr;
    logic          mismatch;
    logic          r_last, c_last, k_last, bcol_last;

    assign mismatch  = (dq.ap != dq.bp) || (dq.cm != dq.am) || (dq.cn != dq.bn);
    assign r_last    = (st == SQ_XPOSE) ? (r == dq.bp - 1'b1) : (r == dq.am - 1'b1);
    assign bcol_last = (c == dq.bn - 1'b1);
    assign c_last    = bcol_last;
    assign k_last    = (k == dq.ap - 1'b1);

    // Transpose pass: B(r,c) word 'part' goes to scratch column c, slot r.
    assign b_addr   = b_ptr;
    assign sc_we    = (st == SQ_XPOSE);
    assign sc_waddr = {c[IW-1:0], r[IW-1:0], part};

    // Dot product pass: A row base plus term, scratch column c slot k.
    assign a_addr    = a_base + AW'({k, part});
    assign sc_raddr  = {c[IW-1:0], k[IW-1:0], part};
    assign mac_lo    = (st == SQ_MAC) && !part;
    assign mac_hi    = (st == SQ_MAC) && part;
    assign mac_first = (k == '0);

    assign c_we   = (st == SQ_WR_RE) || (st == SQ_WR_IM);
    assign c_addr = c_ptr;
    assign sel_im = (st == SQ_WR_IM);
    assign done   = (st == SQ_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_IDLE;
            dq     <= '0;
            r      <= '0;
            c      <= '0;
            k      <= '0;
            part   <= 1'b0;
            b_ptr  <= '0;
            a_base <= '0;
            c_ptr  <= '0;
            status <= 1'b0;
        end else begin
            unique case (st)
                SQ_IDLE: begin
                    if (start) begin
                        dq <= dims_in;
                        st <= SQ_CHECK;
                    end
                end
                SQ_CHECK: begin
                    r      <= '0;
                    c      <= '0;
                    k      <= '0;
                    part   <= 1'b0;
                    b_ptr  <= '0;
                    a_base <= '0;
                    c_ptr  <= '0;
                    status <= mismatch;
                    st     <= mismatch ? SQ_FIN : SQ_XPOSE;
                end
                SQ_XPOSE: begin
                    b_ptr <= b_ptr + 1'b1;
                    part  <= !part;
                    if (part) begin
                        if (bcol_last) begin
                            c <= '0;
                            if (r_last) begin
                                r  <= '0;
                                st <= SQ_MAC;
                            end else begin
                                r <= r + 1'b1;
                            end
                        end else begin
                            c <= c + 1'b1;
                        end
                    end
                end
                SQ_MAC: begin
                    part <= !part;
                    if (part) begin
                        if (k_last) begin
                            k  <= '0;
                            st <= SQ_WR_RE;
                        end else begin
                            k <= k + 1'b1;
                        end
                    end
                end
                SQ_WR_RE: begin
                    c_ptr <= c_ptr + 1'b1;
                    st    <= SQ_WR_IM;
                end
                SQ_WR_IM: begin
                    c_ptr <= c_ptr + 1'b1;
                    st    <= SQ_MAC;
                    if (c_last) begin
                        c      <= '0;
                        a_base <= a_base + AW'({dq.ap, 1'b0});
                        if (r_last) begin
                            r  <= '0;
                            st <= SQ_FIN;
                        end else begin
                            r <= r + 1'b1;
                        end
                    end else begin
                        c <= c + 1'b1;
                    end
                end
                SQ_FIN: begin
                    st <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1: a failed dimension check is never followed by a C write
    a_r1_no_write_on_error: assert property (@(posedge clk) disable iff (rst)
        c_we |-> !status);

    // R8: back-to-back C writes move to the next word address
    a_r8_addr_step: assert property (@(posedge clk) disable iff (rst)
        (c_we && $past(c_we)) |-> (c_addr == $past(c_addr) + 1'b1));

    // R10: the B read pointer advances one word per transpose cycle
    a_r10_b_stream: assert property (@(posedge clk) disable iff (rst)
        (sc_we && $past(sc_we)) |-> (b_addr == $past(b_addr) + 1'b1));

endmodule

// File: rtl/cplx_matmul.sv
module cplx_matmul
    import cmm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] dim_am,
    input  logic [DW-1:0] dim_ap,
    input  logic [DW-1:0] dim_bp,
    input  logic [DW-1:0] dim_bn,
    input  logic [DW-1:0] dim_cm,
    input  logic [DW-1:0] dim_cn,
    output logic          done,
    output logic          status,
    output logic [AW-1:0] a_addr,
    input  logic [15:0]   a_rdata,
    output logic [AW-1:0] b_addr,
    input  logic [15:0]   b_rdata,
    output logic          c_we,
    output logic [AW-1:0] c_addr,
    output logic [15:0]   c_wdata
);

    dims_t         dims_in;
    logic          sc_we;
    logic [AW-1:0] sc_waddr, sc_raddr;
    logic [15:0]   sc_rdata;
    logic          mac_lo, mac_hi, mac_first, sel_im;
    cq15_t         res;

    assign dims_in = '{am: dim_am, ap: dim_ap, bp: dim_bp,
                       bn: dim_bn, cm: dim_cm, cn: dim_cn};

    cmm_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .dims_in   (dims_in),
        .done      (done),
        .status    (status),
        .a_addr    (a_addr),
        .b_addr    (b_addr),
        .sc_we     (sc_we),
        .sc_waddr  (sc_waddr),
        .sc_raddr  (sc_raddr),
        .mac_lo    (mac_lo),
        .mac_hi    (mac_hi),
        .mac_first (mac_first),
        .c_we      (c_we),
        .c_addr    (c_addr),
        .sel_im    (sel_im)
    );

    cmm_scratch u_scratch (
        .clk   (clk),
        .we    (sc_we),
        .waddr (sc_waddr),
        .wdata (b_rdata),
        .raddr (sc_raddr),
        .rdata (sc_rdata)
    );

    cmm_mac u_mac (
        .clk    (clk),
        .rst    (rst),
        .lo_en  (mac_lo),
        .hi_en  (mac_hi),
        .first  (mac_first),
        .a_word (a_rdata),
        .b_word (sc_rdata),
        .res    (res)
    );

    assign c_wdata = sel_im ? res.im : res.re;

    // R9: no write is issued in the completion cycle
    a_r9_done_after_writes: assert property (@(posedge clk) disable iff (rst)
        c_we |-> !done);

endmodule

// File: tb/test_cplx_matmul.sv
module test_cplx_matmul;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [4:0] dim_am = '0, dim_ap = '0, dim_bp = '0;
    logic [4:0] dim_bn = '0, dim_cm = '0, dim_cn = '0;
    logic       done, status, c_we;
    logic [8:0] a_addr, b_addr, c_addr;
    logic [15:0] a_rdata, b_rdata, c_wdata;

    logic [15:0] mem_a [512];
    logic [15:0] mem_b [512];
    logic [15:0] mem_c [512];

    int n_checks = 0;
    int n_errors = 0;
    int wr_cnt = 0;
    int order_bad = 0;

    always #2 clk = !clk;

    assign a_rdata = mem_a[a_addr];
    assign b_rdata = mem_b[b_addr];

    always @(posedge clk) begin
        if (c_we) begin
            mem_c[c_addr] <= c_wdata;
            if (int'(c_addr) != wr_cnt) order_bad = order_bad + 1;
            wr_cnt = wr_cnt + 1;
        end
    end

    cplx_matmul i_cplx_matmul (
        .clk(clk), .rst(rst), .start(start),
        .dim_am(dim_am), .dim_ap(dim_ap), .dim_bp(dim_bp),
        .dim_bn(dim_bn), .dim_cm(dim_cm), .dim_cn(dim_cn),
        .done(done), .status(status),
        .a_addr(a_addr), .a_rdata(a_rdata),
        .b_addr(b_addr), .b_rdata(b_rdata),
        .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint sat16(input longint v);
        longint s = v >>> 15;
        if (s > 32767) return 32767;
        if (s < -32768) return -32768;
        return s;
    endfunction

    function automatic logic [15:0] rnd_word();
        int sel = int'($urandom % 8);
        if (sel == 0) return 16'h8000;
        if (sel == 1) return 16'h7FFF;
        return 16'($urandom);
    endfunction

    // mode 0 random, 1 all -32768 (R6), 2 large negative (R7), 3 -1 products (R5)
    task automatic run(input int m, input int p, input int n, input int bp,
                       input int cm, input int cn, input int mode, input string req);
        int cyc;
        bit ok_dims;
        ok_dims = (bp == p) && (cm == m) && (cn == n);
        for (int w = 0; w < 512; w++) begin
            mem_c[w] = 16'hDEAD;
            case (mode)
                0: begin mem_a[w] = rnd_word(); mem_b[w] = rnd_word(); end
                1: begin mem_a[w] = w[0] ? 16'h0000 : 16'h8000; mem_b[w] = w[0] ? 16'h0000 : 16'h8000; end
                2: begin mem_a[w] = w[0] ? 16'h0000 : 16'h8000; mem_b[w] = w[0] ? 16'h0000 : 16'h7FFF; end
                default: begin mem_a[w] = w[0] ? 16'h0000 : 16'hFFFF; mem_b[w] = w[0] ? 16'h0000 : 16'h0001; end
            endcase
        end
        wr_cnt = 0;
        order_bad = 0;
        @(negedge clk);
        dim_am = 5'(m); dim_ap = 5'(p); dim_bp = 5'(bp);
        dim_bn = 5'(n); dim_cm = 5'(cm); dim_cn = 5'(cn);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R9: scramble the dimensions once the request has been taken
        dim_am = 5'd3; dim_ap = 5'd9; dim_bp = 5'd2; dim_bn = 5'd5; dim_cm = 5'd1; dim_cn = 5'd7;
        cyc = 0;
        while (!done && cyc < 30000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            check(1'b0, "watchdog", cyc, 30000);
            return;
        end
        if (!ok_dims) begin
            check(status == 1'b1, "R1 status", status, 1);
            check(wr_cnt == 0, "R1 writes", wr_cnt, 0);
        end else begin
            check(status == 1'b0, "R2 status", status, 0);
            check(wr_cnt == 2 * m * n, "R8 write count", wr_cnt, 2 * m * n);
            check(order_bad == 0, "R8 write order", order_bad, 0);
            for (int i = 0; i < m; i++) begin
                for (int j = 0; j < n; j++) begin
                    longint sr = 0, si = 0;
                    longint er, ei, ar, ai, br, bi;
                    for (int k = 0; k < p; k++) begin
                        ar = longint'($signed(mem_a[2 * (i * p + k)]));
                        ai = longint'($signed(mem_a[2 * (i * p + k) + 1]));
                        br = longint'($signed(mem_b[2 * (k * n + j)]));
                        bi = longint'($signed(mem_b[2 * (k * n + j) + 1]));
                        sr += ar * br - ai * bi;
                        si += ar * bi + ai * br;
                    end
                    er = sat16(sr);
                    ei = sat16(si);
                    check(longint'($signed(mem_c[2 * (i * n + j)])) == er,
                          {req, " R3 real"}, longint'($signed(mem_c[2 * (i * n + j)])), er);
                    check(longint'($signed(mem_c[2 * (i * n + j) + 1])) == ei,
                          {req, " R4 imag"}, longint'($signed(mem_c[2 * (i * n + j) + 1])), ei);
                end
            end
        end
        @(negedge clk);
        check(done == 1'b0, "R9 done pulse", done, 0);
    endtask

    initial begin
        int seed_init;
        seed_init = int'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R9 reset done", done, 0);
        check(c_we == 1'b0, "R8 reset write", c_we, 0);

        run(3, 4, 2, 5, 3, 2, 0, "R1 inner");
        run(3, 4, 2, 4, 2, 2, 0, "R1 rows");
        run(3, 4, 2, 4, 3, 3, 0, "R1 cols");

        run(3, 5, 4, 5, 3, 4, 0, "random");
        run(1, 1, 1, 1, 1, 1, 0, "R10 single");
        run(2, 7, 3, 7, 2, 3, 0, "R10 odd");
        run(4, 1, 5, 1, 4, 5, 0, "R10 p1");
        run(16, 16, 16, 16, 16, 16, 0, "R10 full");
        run(2, 3, 2, 3, 2, 2, 1, "R6 high");
        run(1, 2, 1, 2, 1, 1, 2, "R7 low");
        run(2, 3, 2, 3, 2, 2, 3, "R5 trunc");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule